// File: doc/BRIEF.md
# Pipelined Read Requester with Tag Pool

This block takes a single read job, given as a start address and a byte length, and breaks it into a series of memory read requests. Each request is sized by three limits: the bytes still to be requested, a maximum request size chosen by a 3-bit code, and the distance to the next 4 KB address boundary. Each request gets a tag from a small pool. The next request goes out while earlier ones are still outstanding, so only the first read of a job waits out the full round trip.

Tags are handed out in a fixed cyclic order. A tag stays busy until a completion that carries that tag and has its last flag set arrives. The data for one request may come back as several partial completions. When the tag due next in the rotation is still busy, issuing stops, even if other tags are already free. The done output rises once every byte of the job has been requested and no tag is busy.

Top module: `rd_requester`

## Requirements
- R1: After reset, job_ready_o is 1, req_valid_o is 0 and done_o is 0.
- R2: The first request of a job starts at the job address. Each later request starts at the previous address plus the previous length. The length is the smallest of three values: the bytes remaining, the maximum request size, and 4096 minus (address mod 4096).
- R3: The size code is sampled when the job is accepted. Codes 0 to 5 give a maximum of 128 << code bytes. Codes 6 and 7 give 4096 bytes.
- R4: No request crosses a 4096-byte address boundary.
- R5: Tags are issued in the order 0,1,...,NUM_TAGS-1 and then wrap back to 0. The rotation continues across jobs rather than restarting.
- R6: Up to NUM_TAGS requests are issued back to back with no completion received in between.
- R7: A tag is freed only by a completion for that tag with cpl_last_i=1. A completion with cpl_last_i=0 leaves the tag busy.
- R8: While the next tag in rotation is busy, req_valid_o stays 0, even when other tags are free.
- R9: job_ready_o is 1 only when no job is running. done_o rises one cycle after the cycle in which the remaining byte count is zero and all tags are free. done_o stays high until the next job is accepted.
- R10: A job of length 0 issues no request and reaches done.
- R11: While req_valid_o=1 and req_ready_i=0, the request stays valid and its address, length and tag do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| job_valid_i | input | 1 | A job is offered |
| job_ready_o | output | 1 | Ready to accept a job (idle) |
| job_addr_i | input | ADDR_W | Job start byte address |
| job_len_i | input | LEN_W | Job length in bytes |
| size_code_i | input | 3 | Maximum request size code |
| req_valid_o | output | 1 | A request is presented |
| req_ready_i | input | 1 | The request is taken |
| req_addr_o | output | ADDR_W | Request byte address |
| req_len_o | output | 13 | Request length in bytes (1 to 4096) |
| req_tag_o | output | TAG_W | Request tag |
| cpl_valid_i | input | 1 | A completion packet arrives |
| cpl_tag_i | input | TAG_W | Tag of the completion |
| cpl_bytes_i | input | 13 | Bytes carried by the completion |
| cpl_last_i | input | 1 | Final completion for this tag |
| done_o | output | 1 | Job finished and all tags free |

## Verification
The bench builds the block with ADDR_W=32, LEN_W=20 and NUM_TAGS=4. Four tags are enough to make the rotation wrap several times within one job. They also let a stall be forced after exactly four issued requests. The bench completer splits every request into packets on 128-byte aligned boundaries, so completions arrive as several partial packets per tag. The job table covers jobs that meet a 4 KB boundary, the clamped size codes, and runs with request backpressure. Directed cases cover a zero-length job and out-of-order freeing against the in-order rotation.

// File: rtl/rdreq_pkg.sv
package rdreq_pkg;
  localparam int unsigned RQ_LEN_W = 13;
  localparam int unsigned PAGE_W   = 12;

  typedef enum logic [0:0] {ST_IDLE, ST_RUN} rq_state_e;

  // size code -> byte limit; codes above 5 are clamped to 4096
  function automatic logic [RQ_LEN_W-1:0] code_to_bytes(input logic [2:0] code);
    logic [2:0] c;
    c = (code > 3'd5) ? 3'd5 : code;
    return RQ_LEN_W'(13'd128 << c);
  endfunction
endpackage

// File: rtl/rdreq_len_calc.sv
module rdreq_len_calc
  import rdreq_pkg::*;
#(
  parameter int unsigned LEN_W = 20
) (
  input  logic [PAGE_W-1:0]   page_off_i,
  input  logic [LEN_W-1:0]    remain_i,
  input  logic [2:0]          size_code_i,
  output logic [RQ_LEN_W-1:0] len_o
);
  logic [RQ_LEN_W-1:0] room, limit, cap;

  always_comb begin
    room  = RQ_LEN_W'(4096) - {1'b0, page_off_i};
    limit = code_to_bytes(size_code_i);
    cap   = (room < limit) ? room : limit;
    len_o = (remain_i > LEN_W'(cap)) ? cap : remain_i[RQ_LEN_W-1:0];
  end
endmodule

// File: rtl/rdreq_tag_pool.sv
module rdreq_tag_pool
  import rdreq_pkg::*;
#(
  parameter  int unsigned NUM_TAGS = 4,
  localparam int unsigned TAG_W    = (NUM_TAGS > 1) ? $clog2(NUM_TAGS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                issue_i,
  input  logic [RQ_LEN_W-1:0] issue_len_i,
  input  logic                cpl_valid_i,
  input  logic [TAG_W-1:0]    cpl_tag_i,
  input  logic [RQ_LEN_W-1:0] cpl_bytes_i,
  input  logic                cpl_last_i,
  output logic [TAG_W-1:0]    next_tag_o,
  output logic                next_free_o,
  output logic                all_free_o
);
  logic [NUM_TAGS-1:0] busy_q;
  logic [TAG_W-1:0]    ptr_q;
  logic [RQ_LEN_W-1:0] left_q [NUM_TAGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (issue_i) begin
      ptr_q <= (ptr_q == TAG_W'(NUM_TAGS-1)) ? '0 : ptr_q + 1'b1;
    end
  end

  for (genvar t = 0; t < NUM_TAGS; t++) begin : g_tag
    logic take, back;
    assign take = issue_i && (ptr_q == TAG_W'(t));
    assign back = cpl_valid_i && (cpl_tag_i == TAG_W'(t));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        busy_q[t] <= 1'b0;
        left_q[t] <= '0;
      end else if (take) begin
        busy_q[t] <= 1'b1;
        left_q[t] <= issue_len_i;
      end else if (back) begin
        left_q[t] <= left_q[t] - cpl_bytes_i;
        if (cpl_last_i) busy_q[t] <= 1'b0;
      end
    end
  end

  assign next_tag_o  = ptr_q;
  assign next_free_o = !busy_q[ptr_q];
  assign all_free_o  = (busy_q == '0);

  // R8: never hand out a tag that is still in flight
  a_r8_issue_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i |-> !busy_q[ptr_q]);
  // R7: completions only target busy tags
  a_r7_cpl_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpl_valid_i |-> busy_q[cpl_tag_i]);
  // R7: the last completion drains exactly the bytes left for its tag
  a_r7_last_drain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpl_valid_i && cpl_last_i) |-> (left_q[cpl_tag_i] == cpl_bytes_i));
  // R7: a partial completion leaves the tag busy
  a_r7_partial_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpl_valid_i && !cpl_last_i && !issue_i) |=> !all_free_o);
endmodule

// File: rtl/rd_requester.sv
module rd_requester
  import rdreq_pkg::*;
#(
  parameter  int unsigned ADDR_W   = 32,
  parameter  int unsigned LEN_W    = 20,
  parameter  int unsigned NUM_TAGS = 4,
  localparam int unsigned TAG_W    = (NUM_TAGS > 1) ? $clog2(NUM_TAGS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                job_valid_i,
  output logic                job_ready_o,
  input  logic [ADDR_W-1:0]   job_addr_i,
  input  logic [LEN_W-1:0]    job_len_i,
  input  logic [2:0]          size_code_i,
  output logic                req_valid_o,
  input  logic                req_ready_i,
  output logic [ADDR_W-1:0]   req_addr_o,
  output logic [RQ_LEN_W-1:0] req_len_o,
  output logic [TAG_W-1:0]    req_tag_o,
  input  logic                cpl_valid_i,
  input  logic [TAG_W-1:0]    cpl_tag_i,
  input  logic [RQ_LEN_W-1:0] cpl_bytes_i,
  input  logic                cpl_last_i,
  output logic                done_o
);
  rq_state_e          state_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [LEN_W-1:0]   remain_q;
  logic [2:0]         code_q;
  logic               done_q;
  logic               tag_free, all_free, issue, accept, finish;
  logic [TAG_W-1:0]   next_tag;
  logic [RQ_LEN_W-1:0] cur_len;

  rdreq_len_calc #(.LEN_W(LEN_W)) u_len (
    .page_off_i (addr_q[PAGE_W-1:0]),
    .remain_i   (remain_q),
    .size_code_i(code_q),
    .len_o      (cur_len)
  );

  rdreq_tag_pool #(.NUM_TAGS(NUM_TAGS)) u_pool (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .issue_i    (issue),
    .issue_len_i(cur_len),
    .cpl_valid_i(cpl_valid_i),
    .cpl_tag_i  (cpl_tag_i),
    .cpl_bytes_i(cpl_bytes_i),
    .cpl_last_i (cpl_last_i),
    .next_tag_o (next_tag),
    .next_free_o(tag_free),
    .all_free_o (all_free)
  );

  assign job_ready_o = (state_q == ST_IDLE);
  assign accept      = job_ready_o && job_valid_i;
  assign req_valid_o = (state_q == ST_RUN) && (remain_q != '0) && tag_free;
  assign issue       = req_valid_o && req_ready_i;
  assign finish      = (state_q == ST_RUN) && (remain_q == '0) && all_free;
  assign req_addr_o  = addr_q;
  assign req_len_o   = cur_len;
  assign req_tag_o   = next_tag;
  assign done_o      = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      remain_q <= '0;
      code_q   <= '0;
      done_q   <= 1'b0;
    end else begin
      if (accept) begin
        state_q  <= ST_RUN;
        addr_q   <= job_addr_i;
        remain_q <= job_len_i;
        code_q   <= size_code_i;
        done_q   <= 1'b0;
      end else if (finish) begin
        state_q  <= ST_IDLE;
        done_q   <= 1'b1;
      end else if (issue) begin
        addr_q   <= addr_q + ADDR_W'(cur_len);
        remain_q <= remain_q - LEN_W'(cur_len);
      end
    end
  end

  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ready_i) |=>
      (req_valid_o && $stable(req_addr_o) && $stable(req_len_o) && $stable(req_tag_o)));
  a_r4_no_cross: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> (({1'b0, req_addr_o[PAGE_W-1:0]} + req_len_o) <= 13'd4096));
  a_r3_len_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> ((req_len_o != '0) && (req_len_o <= code_to_bytes(code_q))));
  a_r2_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue |=> (req_addr_o == $past(req_addr_o) + ADDR_W'($past(req_len_o))));
  a_r9_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (job_ready_o && all_free));
endmodule

// File: tb/rd_requester_bench.sv
module rd_requester_bench;
  localparam int NT  = 4;
  localparam int LAT = 6;

  typedef struct packed {
    logic [31:0] a;
    logic [19:0] l;
    logic [2:0]  c;
    logic        bp;
  } vec_t;

  // addr, length, size code, backpressure
  localparam vec_t VECS [6] = '{
    '{32'h0000_1000, 20'd1024,  3'd2, 1'b0},
    '{32'h0000_0F80, 20'd600,   3'd1, 1'b1},
    '{32'h0000_2FF4, 20'd40,    3'd5, 1'b0},
    '{32'h0000_0000, 20'd10000, 3'd7, 1'b1},
    '{32'h0000_0123, 20'd3000,  3'd0, 1'b1},
    '{32'h0000_0005, 20'd1,     3'd3, 1'b0}
  };

  logic        clk_i = 0, rst_ni = 0;
  logic        job_valid_i = 0, job_ready_o;
  logic [31:0] job_addr_i = 0;
  logic [19:0] job_len_i = 0;
  logic [2:0]  size_code_i = 0;
  logic        req_valid_o, req_ready_i = 0;
  logic [31:0] req_addr_o;
  logic [12:0] req_len_o;
  logic [1:0]  req_tag_o;
  logic        cpl_valid_i = 0, cpl_last_i = 0;
  logic [1:0]  cpl_tag_i = 0;
  logic [12:0] cpl_bytes_i = 0;
  logic        done_o;

  rd_requester #(.ADDR_W(32), .LEN_W(20), .NUM_TAGS(NT)) u_rd_requester (.*);

  always #10 clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0, cyc = 0, exp_tag = 0, req_cnt = 0;
  longint m_addr, m_rem;
  int m_code;
  int pk_tag[2048], pk_bytes[2048], pk_last[2048], pk_time[2048];
  int pk_wr = 0, pk_rd = 0;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  function automatic longint exp_len(input longint a, input longint r, input int c);
    longint lim, room, v;
    lim  = 128 << ((c > 5) ? 5 : c);
    room = 4096 - (a % 4096);
    v = r;
    if (lim < v) v = lim;
    if (room < v) v = room;
    return v;
  endfunction

  // completions split on 128-byte aligned boundaries
  task automatic push_pkts(input int tag, input longint a, input longint len);
    longint c, r;
    r = len;
    while (r > 0) begin
      c = 128 - (a % 128);
      if (c > r) c = r;
      pk_tag[pk_wr] = tag; pk_bytes[pk_wr] = int'(c);
      pk_last[pk_wr] = (r == c); pk_time[pk_wr] = cyc + LAT;
      pk_wr++;
      a += c; r -= c;
    end
  endtask

  task automatic start_job(input longint a, input longint l, input int c);
    @(negedge clk_i);
    chk(job_ready_o == 1, "R9", "job_ready idle", job_ready_o, 1);
    job_valid_i = 1; job_addr_i = a[31:0]; job_len_i = l[19:0]; size_code_i = c[2:0];
    @(negedge clk_i);
    job_valid_i = 0;
    chk(job_ready_o == 0, "R9", "job_ready running", job_ready_o, 0);
    m_addr = a; m_rem = l; m_code = c; req_cnt = 0;
  endtask

  task automatic send_cpl(input int tag, input int bytes, input bit last);
    cpl_valid_i = 1; cpl_tag_i = tag[1:0]; cpl_bytes_i = bytes[12:0]; cpl_last_i = last;
    @(negedge clk_i);
    cpl_valid_i = 0; cpl_last_i = 0;
  endtask

  task automatic run_job(input bit bp);
    bit prev_stall = 0;
    logic [31:0] s_addr; logic [12:0] s_len; logic [1:0] s_tag;
    longint el;
    for (int g = 0; g < 5000; g++) begin
      if (done_o) begin
        chk(m_rem == 0 && pk_rd == pk_wr, "R9", "done only when all requested and freed",
            m_rem + (pk_wr - pk_rd), 0);
        cpl_valid_i = 0;
        return;
      end
      req_ready_i = bp ? ((cyc % 4) != 1) : 1'b1;
      if (pk_rd < pk_wr && pk_time[pk_rd] <= cyc) begin
        cpl_valid_i = 1; cpl_tag_i = pk_tag[pk_rd][1:0];
        cpl_bytes_i = pk_bytes[pk_rd][12:0]; cpl_last_i = pk_last[pk_rd][0];
        pk_rd++;
      end else begin
        cpl_valid_i = 0; cpl_last_i = 0;
      end
      #1;
      if (prev_stall)
        chk(req_valid_o && req_addr_o == s_addr && req_len_o == s_len && req_tag_o == s_tag,
            "R11", "held request", req_addr_o, s_addr);
      if (req_valid_o && m_rem == 0)
        chk(0, "R10", "request beyond job", req_len_o, 0);
      else if (req_valid_o && req_ready_i) begin
        el = exp_len(m_addr, m_rem, m_code);
        chk(req_addr_o == m_addr[31:0], "R2", "req addr", req_addr_o, m_addr);
        chk(req_len_o == el, "R2", "req len", req_len_o, el);
        chk(req_tag_o == exp_tag, "R5", "req tag", req_tag_o, exp_tag);
        chk((m_addr % 4096) + req_len_o <= 4096, "R4", "page end", (m_addr % 4096) + req_len_o, 4096);
        push_pkts(exp_tag, m_addr, el);
        m_addr += el; m_rem -= el; exp_tag = (exp_tag + 1) % NT; req_cnt++;
      end
      prev_stall = req_valid_o && !req_ready_i;
      s_addr = req_addr_o; s_len = req_len_o; s_tag = req_tag_o;
      @(negedge clk_i);
    end
    chk(0, "R9", "job never finished", 0, 1);
  endtask

  initial begin
    int b, cnt;
    repeat (3) @(negedge clk_i);
    chk(job_ready_o == 1, "R1", "reset job_ready", job_ready_o, 1);
    chk(req_valid_o == 0, "R1", "reset req_valid", req_valid_o, 0);
    chk(done_o == 0, "R1", "reset done", done_o, 0);
    rst_ni = 1;

    // table walk; R3 clamp exercised by code 7, R4 by 0xF80 and 0x2FF4
    for (int v = 0; v < 6; v++) begin
      start_job(VECS[v].a, VECS[v].l, VECS[v].c);
      run_job(VECS[v].bp);
      chk(done_o == 1, "R9", "done after job", done_o, 1);
    end
    repeat (3) @(negedge clk_i);
    chk(done_o == 1, "R9", "done held while idle", done_o, 1);

    // R10: zero-length job
    start_job(64, 0, 3);
    chk(done_o == 0, "R9", "done cleared on accept", done_o, 0);
    run_job(0);
    chk(req_cnt == 0, "R10", "requests for empty job", req_cnt, 0);

    // R6/R7/R8: no completions, then out-of-order and partial frees
    start_job(0, 640, 0);
    req_ready_i = 1; cpl_valid_i = 0;
    b = exp_tag; cnt = 0;
    for (int k = 0; k < 12; k++) begin
      #1;
      if (req_valid_o && req_ready_i) begin
        chk(req_tag_o == exp_tag, "R5", "stall test tag", req_tag_o, exp_tag);
        chk(req_addr_o == cnt * 128, "R2", "stall test addr", req_addr_o, cnt * 128);
        exp_tag = (exp_tag + 1) % NT; cnt++;
      end
      @(negedge clk_i);
    end
    chk(cnt == NT, "R6", "requests in flight without completions", cnt, NT);
    chk(req_valid_o == 0, "R8", "stall on busy tag", req_valid_o, 0);
    chk(done_o == 0, "R9", "no done with busy tags", done_o, 0);
    send_cpl((b + 1) % NT, 128, 1);
    @(negedge clk_i);
    chk(req_valid_o == 0, "R8", "other tag free, next busy", req_valid_o, 0);
    send_cpl(b, 64, 0);
    @(negedge clk_i);
    chk(req_valid_o == 0, "R7", "partial completion keeps tag", req_valid_o, 0);
    send_cpl(b, 64, 1);
    #1;
    chk(req_valid_o == 1, "R7", "last completion frees tag", req_valid_o, 1);
    chk(req_tag_o == b, "R5", "reused tag", req_tag_o, b);
    chk(req_addr_o == 512, "R2", "fifth addr", req_addr_o, 512);
    @(negedge clk_i);
    exp_tag = (exp_tag + 1) % NT;
    chk(req_valid_o == 0, "R8", "stall after fifth", req_valid_o, 0);
    send_cpl((b + 2) % NT, 128, 1);
    send_cpl((b + 3) % NT, 128, 1);
    send_cpl(b, 128, 1);
    chk(done_o == 0, "R9", "done one cycle after free", done_o, 0);
    @(negedge clk_i);
    chk(done_o == 1, "R9", "done after last free", done_o, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule